// File: doc/BRIEF.md
# Timed-Token Station Access Controller

This block arbitrates one station's use of a token-passing ring. When a one-cycle arrival pulse announces that the token has reached the station, the controller always holds it for a fixed synchronous allocation, during which the traffic source may send time-critical frames. At the end of that allocation it looks at how long the token took to come round. If the rotation was slow, it gives the token straight back with a one-cycle release pulse. If the rotation was fast, it opens an asynchronous window instead.

An asynchronous window ends when the traffic source reports it has finished, or when the rotation measurement reaches the target, whichever comes first. Rotation is measured by two saturating timers that take turns. On each visit the arrival clears the idle timer and the holding timer. The other timer, which has been running since the previous visit, is the one compared against the target. Each release hands the roles over, so every timer spans two token visits.

Status outputs tell the traffic source which kind of traffic it may send. A token arrival seen while the station already holds the token is discarded and raises a sticky error flag.

Top module: `token_station_mac`

## Requirements
- R1: A synchronous active-low reset puts the controller in the idle state of the first phase (timer A checked on the next visit), clears all three timers, and drives every output low.
- R2: After each accepted arrival pulse, `sync_active` is high for exactly SYNC_ALLOC consecutive cycles, starting the cycle after the arrival edge; no release decision is made before the last of them.
- R3: If the checked timer is at or above TARGET_ROT in the last synchronous cycle, `tok_release` pulses in that same cycle and `async_active` never rises for that visit.
- R4: Otherwise the controller enters the asynchronous state. It pulses `tok_release` in the cycle in which the checked timer equals TARGET_ROT, unless the release has already happened; the checked timer never exceeds TARGET_ROT while `async_active` is high.
- R5: In the asynchronous state, a high `async_done` releases the token in that same cycle.
- R6: The first accepted arrival after reset checks timer A and clears timer B. Every release switches to the other phase's idle state. An accepted arrival clears the non-checked rotation timer and the holding timer to zero, so each timer measures from the arrival that cleared it.
- R7: All timers add one per clock and hold at 2^TMR_W-1 instead of wrapping.
- R8: An arrival pulse while the controller is not idle has no effect on the visit in progress and sets `proto_err`, which stays high until reset.
- R9: `tok_release` is never high in two consecutive cycles and only occurs while the token is held; `sync_active` and `async_active` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; timers advance once per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_arrive | input | 1 | One-cycle pulse: token has reached this station |
| async_done | input | 1 | Traffic source has no more asynchronous data |
| tok_release | output | 1 | One-cycle pulse: token is passed on |
| sync_active | output | 1 | Synchronous traffic may be sent |
| async_active | output | 1 | Asynchronous traffic may be sent |
| proto_err | output | 1 | Sticky flag: arrival seen while token held |

## Verification
The bench builds the block with SYNC_ALLOC=4, TARGET_ROT=30 and TMR_W=6. With these values a timer saturates at 63 after a gap of a few dozen cycles, so the saturation case (R7) can be reached with a short idle gap. A wrapping timer would then report a small value and wrongly open an asynchronous window. The short allocation and target also let one run cover, in a few hundred cycles, windows that end at the target, windows cut short by `async_done`, immediate releases after a slow rotation, and a stray arrival in the middle of a visit.

// File: rtl/tsm_pkg.sv
// Shared types for the timed-token station access controller.
// Assumes: six states, two phases of three states each.
package tsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_A  = 3'd0,
        ST_SYNC_A  = 3'd1,
        ST_ASYNC_A = 3'd2,
        ST_IDLE_B  = 3'd3,
        ST_SYNC_B  = 3'd4,
        ST_ASYNC_B = 3'd5
    } tsm_state_e;

endpackage

// File: rtl/tsm_sat_timer.sv
// Saturating up-counter used for the rotation and holding timers.
// Counts one per clock, holds at all-ones, clears to zero on clr or reset.
// Assumes: clr is a single-cycle request from the phase FSM.
module tsm_sat_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count register: clear, advance, or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV)); // R7

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R6

endmodule

// File: rtl/tsm_phase_fsm.sv
// Phase state machine: accepts token arrivals, runs the synchronous
// allocation, decides on an asynchronous window, and releases the token.
// Assumes: timer values arrive registered from tsm_sat_timer instances.
module tsm_phase_fsm
    import tsm_pkg::*;
#(
    parameter int SYNC_ALLOC = 20,
    parameter int TARGET_ROT = 620,
    parameter int TMR_W      = 10,
    parameter int HOLD_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_arrive,
    input  logic              async_done,
    input  logic [HOLD_W-1:0] hold_cnt,
    input  logic [TMR_W-1:0]  rot_a,
    input  logic [TMR_W-1:0]  rot_b,
    output logic              hold_clr,
    output logic [1:0]        rot_clr,
    output logic              tok_release,
    output logic              sync_active,
    output logic              async_active,
    output logic              proto_err
);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(SYNC_ALLOC - 1);
    localparam logic [TMR_W-1:0]  TGT_C     = TMR_W'(TARGET_ROT);

    tsm_state_e state, state_nx;
    logic       phase_b, idle, in_sync, in_async, accept;
    logic [TMR_W-1:0] chk;

    // Decode the current state into phase and activity.
    always_comb begin
        phase_b  = (state == ST_IDLE_B) || (state == ST_SYNC_B) || (state == ST_ASYNC_B);
        idle     = (state == ST_IDLE_A) || (state == ST_IDLE_B);
        in_sync  = (state == ST_SYNC_A) || (state == ST_SYNC_B);
        in_async = (state == ST_ASYNC_A) || (state == ST_ASYNC_B);
        chk      = phase_b ? rot_b : rot_a;
        accept   = idle && tok_arrive;
    end

    // Release decision and next-state selection.
    always_comb begin
        state_nx    = state;
        tok_release = 1'b0;
        if (accept) begin
            state_nx = phase_b ? ST_SYNC_B : ST_SYNC_A;
        end else if (in_sync && hold_cnt == HOLD_LAST) begin
            if (chk >= TGT_C) begin
                tok_release = 1'b1;
                state_nx    = phase_b ? ST_IDLE_A : ST_IDLE_B;
            end else begin
                state_nx    = phase_b ? ST_ASYNC_B : ST_ASYNC_A;
            end
        end else if (in_async && (async_done || chk >= TGT_C)) begin
            tok_release = 1'b1;
            state_nx    = phase_b ? ST_IDLE_A : ST_IDLE_B;
        end
    end

    // Timer clear requests: the arrival clears the idle timer and the holder.
    always_comb begin
        hold_clr   = accept;
        rot_clr[0] = accept && phase_b;
        rot_clr[1] = accept && !phase_b;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE_A;
        else        state <= state_nx;
    end

    // Sticky protocol-error flag for arrivals while the token is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                 proto_err <= 1'b0;
        else if (tok_arrive && !idle) proto_err <= 1'b1;
    end

    assign sync_active  = in_sync;
    assign async_active = in_async;

    AST_SYNC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && tok_release) |-> (hold_cnt == HOLD_LAST)); // R2

    AST_ASYNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_async |-> (chk <= TGT_C)); // R4

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_release |=> !tok_release); // R9

    AST_PHASE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_release && !phase_b) |=> (state == ST_IDLE_B)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R8

endmodule

// File: rtl/token_station_mac.sv
// Top level of the timed-token station access controller.
// Holds two rotation timers that alternate roles, one holding timer and
// the phase FSM. Assumes: tok_arrive is a single-cycle pulse and
// TARGET_ROT fits below the timer ceiling 2^TMR_W-1.
module token_station_mac #(
    parameter int SYNC_ALLOC = 20,
    parameter int TARGET_ROT = 620,
    parameter int TMR_W      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_arrive,
    input  logic async_done,
    output logic tok_release,
    output logic sync_active,
    output logic async_active,
    output logic proto_err
);
    localparam int HOLD_W = $clog2(SYNC_ALLOC + 1);

    logic [1:0]        rot_clr;
    logic              hold_clr;
    logic [TMR_W-1:0]  rot_cnt [2];
    logic [HOLD_W-1:0] hold_cnt;

    // One saturating counter per rotation timer (index 0 = A, 1 = B).
    for (genvar gi = 0; gi < 2; gi++) begin : g_rot
        tsm_sat_timer #(.W(TMR_W)) u_rot (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (rot_clr[gi]),
            .cnt  (rot_cnt[gi])
        );
    end

    tsm_sat_timer #(.W(HOLD_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (hold_clr),
        .cnt  (hold_cnt)
    );

    tsm_phase_fsm #(
        .SYNC_ALLOC(SYNC_ALLOC),
        .TARGET_ROT(TARGET_ROT),
        .TMR_W     (TMR_W),
        .HOLD_W    (HOLD_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_arrive  (tok_arrive),
        .async_done  (async_done),
        .hold_cnt    (hold_cnt),
        .rot_a       (rot_cnt[0]),
        .rot_b       (rot_cnt[1]),
        .hold_clr    (hold_clr),
        .rot_clr     (rot_clr),
        .tok_release (tok_release),
        .sync_active (sync_active),
        .async_active(async_active),
        .proto_err   (proto_err)
    );

    AST_EXCL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_active && async_active)); // R9

    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tok_release |-> (sync_active || async_active)); // R9

endmodule

// File: tb/token_station_mac_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each release, the monitor compares.
module token_station_mac_test;
    localparam int S    = 4;
    localparam int TGT  = 30;
    localparam int W    = 6;
    localparam int MAXV = (1 << W) - 1;

    typedef struct {
        int    n;
        bit    asy;
        string tag;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, tok_arrive = 1'b0, async_done = 1'b0;
    logic tok_release, sync_active, async_active, proto_err;

    int    edge_n = 0, n_tests = 0, n_fail = 0, sync_cnt = 0;
    int    clr_a = 0, clr_b = 0;
    bit    phase_b = 1'b0, prev_rel = 1'b0, finished = 1'b0;
    item_t exp_q[$];

    token_station_mac #(.SYNC_ALLOC(S), .TARGET_ROT(TGT), .TMR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tok_arrive(tok_arrive), .async_done(async_done),
        .tok_release(tok_release), .sync_active(sync_active),
        .async_active(async_active), .proto_err(proto_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: one token visit; predicts release edge from its own timer model.
    task automatic token(input int gap, input int d, input bit bad, input string tag);
        int e, v, exp_n, cc;
        bit asy;
        item_t it;
        repeat (gap) @(negedge clk);
        tok_arrive = 1'b1;
        e  = edge_n + 1;
        cc = phase_b ? clr_b : clr_a;
        v  = e + S - 1 - cc;
        if (v > MAXV) v = MAXV;
        if (v >= TGT) begin
            exp_n = e + S - 1; asy = 1'b0;
        end else begin
            exp_n = cc + TGT;
            if (d >= 0 && e + S + d < exp_n) exp_n = e + S + d;
            asy = 1'b1;
        end
        it.n = exp_n; it.asy = asy; it.tag = tag;
        exp_q.push_back(it);
        if (phase_b) clr_a = e; else clr_b = e;
        phase_b = !phase_b;
        @(negedge clk);
        tok_arrive = 1'b0;
        while (exp_q.size() != 0) begin
            tok_arrive = (bad && edge_n == e + 1);
            if (d >= 0 && edge_n >= e + S + d) async_done = 1'b1;
            @(negedge clk);
        end
        tok_arrive = 1'b0;
        async_done = 1'b0;
    endtask

    // Monitor: pops the prediction on every release and compares.
    always @(posedge clk) begin
        #4;
        if (rst_n && !finished) begin
            if (sync_active) sync_cnt++;
            if (tok_release) begin
                chk(!prev_rel, "R9 single-cycle release", 1, 0);
                chk(!(sync_active && async_active), "R9 exclusive status", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected release", edge_n, -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(edge_n == it.n, {it.tag, " release cycle"}, edge_n, it.n);
                    chk(async_active == it.asy, {it.tag, " async window"}, int'(async_active), int'(it.asy));
                    chk(sync_cnt == S, "R2 sync length", sync_cnt, S);
                end
                sync_cnt = 0;
            end
            prev_rel = tok_release;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tok_release == 1'b0, "R1 reset release", int'(tok_release), 0);
        chk(sync_active == 1'b0, "R1 reset sync", int'(sync_active), 0);
        chk(async_active == 1'b0, "R1 reset async", int'(async_active), 0);
        chk(proto_err == 1'b0, "R1 reset error", int'(proto_err), 0);
        clr_a = edge_n; clr_b = edge_n;
        rst_n = 1'b1;
        token(0, -1, 1'b0, "R1 R4");   // phase A, window runs to target
        token(0, -1, 1'b0, "R6 R4");   // phase B, timer B from first arrival
        token(0, 2, 1'b0, "R5");       // early finish on async_done
        token(40, -1, 1'b0, "R3");     // slow rotation: immediate release
        token(0, 1, 1'b0, "R5 R6");
        token(75, -1, 1'b0, "R7");     // timer must hold at ceiling
        chk(proto_err == 1'b0, "R8 no error yet", int'(proto_err), 0);
        token(0, -1, 1'b1, "R8");      // stray arrival mid-visit ignored
        chk(proto_err == 1'b1, "R8 error raised", int'(proto_err), 1);
        token(0, 3, 1'b0, "R8 R5");
        chk(proto_err == 1'b1, "R8 error sticky", int'(proto_err), 1);
        repeat (3) @(negedge clk);
        chk(tok_release == 1'b0, "R9 idle no release", int'(tok_release), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule